// File: doc/BRIEF.md
# Execution Context Flag Encoder

This block condenses the machine state word, a few monitor and debug controls, and a set of core-configuration straps into one registered context-flag word and two 3-bit translation-mode indices, one for instruction fetch and one for data access. A fetch and translate stage downstream uses these values to tell execution contexts apart. A full-recompute strobe rebuilds everything. A lighter partial-update strobe refreshes only the performance-monitor field and leaves every other bit as it was.

Some state bits are copied into the flag word at the bit positions they hold in the state word. Other flags are derived. One is a hypervisor flag. Two are single-step and branch-trace flags, which come either from a debug-event scheme or straight from the state word. The remaining derived flags are the monitor flags, including a branch-history recording enable that passes through a layered freeze rule. The meaning of the translation indices depends on whether the core uses a server-style or an embedded-style MMU. An optional consistency output compares the registered values with a fresh computation.

Top module: `ctx_flag_encoder`

## Requirements
- R1: While reset is asserted, and after it, `flags_q`, `iidx_q` and `didx_q` are all zero until the first strobe.
- R2: One cycle after `full_upd`, flag bits 0, 4, 13 and 14 equal state bits 0 (little-endian), 4 (data relocate), 13 (float available) and 14 (problem state). Every flag bit that no requirement names is 0.
- R3: One cycle after `full_upd`, bit 0 of both indices equals the inverse of state bit 14 (problem state).
- R4: With `cfg_embedded_mmu`=0, index bit 2 equals state bit 60 (hypervisor). `iidx_q[1]` is the inverse of state bit 5 (instruction relocate), and `didx_q[1]` is the inverse of state bit 4 (data relocate).
- R5: With `cfg_embedded_mmu`=1, index bit 2 equals state bit 28 (guest state). `iidx_q[1]` equals state bit 8 (instruction space), and `didx_q[1]` equals state bit 7 (data space).
- R6: Flag bit 1 (hypervisor) is 1 when `cfg_has_hv`=0 or state bit 60 is 1.
- R7: With `cfg_dbg_event`=1, flag bit 10 (single-step) is `dbg_step_cmp` AND state bit 11 (debug enable), and flag bit 9 (branch trace) is `dbg_branch_cmp` AND state bit 11. With `cfg_dbg_event`=0, bit 10 is state bit 10 AND `cfg_has_step`, and bit 9 is state bit 9 AND `cfg_has_btrace`.
- R8: Flag bits 16, 17 and 18 copy `pm_cnt_ctl[0]`, `[1]` and `[2]`. Bit 20 is 1 when `pm_summary` is nonzero. Bit 21 is 1 when any of `pm_summary[4:1]` is set.
- R9: Flag bit 19 (branch-history enable) is 0 under any of these conditions:
  - `cfg_isa_new`=1 and either `pm_bh_disable`=1 or problem state is 0;
  - `pm_frz_qual`=1, `pm_frz`=1, hypervisor=1 and problem state=1;
  - `pm_frz_qual`=1, `pm_frz`=0, hypervisor=0 and problem state=1;
  - `pm_frz_qual`=0 with `pm_frz`=1 and problem state=1.
  Otherwise bit 19 is 1.
- R10: One cycle after `pmu_upd` alone, flag bits 16 to 21 are recomputed from the current inputs. All other flag bits and both indices keep their previous values.
- R11: With no strobe, the flag word and indices hold.
- R12: When `full_upd` and `pmu_upd` are both asserted, the full recompute applies.
- R13: With CHECK_EN=1, `mismatch` is 1 exactly when the registered flag word or either registered index differs from the values computed from the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_upd | input | 1 | Full recompute strobe |
| pmu_upd | input | 1 | Monitor-field-only refresh strobe |
| st_word | input | ST_W | Machine state word |
| cfg_has_hv | input | 1 | Core implements a hypervisor mode |
| cfg_embedded_mmu | input | 1 | Embedded-style MMU (1) or server-style (0) |
| cfg_dbg_event | input | 1 | Debug-event style single-step and branch trace |
| cfg_has_step | input | 1 | Single-step bit present in state word |
| cfg_has_btrace | input | 1 | Branch-trace bit present in state word |
| cfg_isa_new | input | 1 | Newer ISA level branch-history qualification |
| dbg_step_cmp | input | 1 | Debug control: instruction-compare event enable |
| dbg_branch_cmp | input | 1 | Debug control: branch-taken event enable |
| pm_cnt_ctl | input | 3 | Monitor counter-control bits |
| pm_frz | input | 1 | Monitor freeze bit |
| pm_frz_qual | input | 1 | Monitor freeze qualifier bit |
| pm_bh_disable | input | 1 | Branch-history recording disable |
| pm_summary | input | SUM_W | Counter-enable summary |
| flags_q | output | FLAG_W | Registered context-flag word |
| iidx_q | output | 3 | Registered instruction translation index |
| didx_q | output | 3 | Registered data translation index |
| mismatch | output | 1 | Registered values differ from a fresh computation |

## Verification
The full-recompute and monitor-only strobes can arrive in the same cycle. If the partial path wins, it leaves stale state bits and indices in the register. The bench drives both strobes together, from random state and from directed state, after the state word has changed since the last full update. It checks that the whole word and both indices match a full recompute, and that `mismatch` then reads 0.

// File: rtl/ctx_flag_pkg.sv
package ctx_flag_pkg;
  // State word bit positions
  localparam int ST_LE = 0;
  localparam int ST_DR = 4;
  localparam int ST_IR = 5;
  localparam int ST_DS = 7;
  localparam int ST_IS = 8;
  localparam int ST_BE = 9;
  localparam int ST_SE = 10;
  localparam int ST_DE = 11;
  localparam int ST_FP = 13;
  localparam int ST_PR = 14;
  localparam int ST_GS = 28;
  localparam int ST_HV = 60;
  // Flag word bit positions (pass-through bits reuse the state positions)
  localparam int FL_HV   = 1;
  localparam int FL_BE   = 9;
  localparam int FL_SE   = 10;
  localparam int FL_CC0  = 16;
  localparam int FL_CC1  = 17;
  localparam int FL_CJ   = 18;
  localparam int FL_BHR  = 19;
  localparam int FL_ICNT = 20;
  localparam int FL_POTH = 21;
  localparam int PM_FIELD_W = 6;
endpackage

// File: rtl/ctx_mode_index.sv
module ctx_mode_index (
  input  logic       pr,
  input  logic       hv,
  input  logic       gs,
  input  logic       ir,
  input  logic       dr,
  input  logic       is_sp,
  input  logic       ds_sp,
  input  logic       embedded,
  output logic [2:0] iidx,
  output logic [2:0] didx
);
  logic top_bit;
  logic i_mid;
  logic d_mid;

  always_comb begin
    if (embedded) begin
      top_bit = gs;
      i_mid   = is_sp;
      d_mid   = ds_sp;
    end else begin
      top_bit = hv;
      i_mid   = ~ir;
      d_mid   = ~dr;
    end
    iidx = {top_bit, i_mid, ~pr};
    didx = {top_bit, d_mid, ~pr};
  end
endmodule

// File: rtl/ctx_pmu_flags.sv
module ctx_pmu_flags
  import ctx_flag_pkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int SUM_W  = 5
) (
  input  logic              pr,
  input  logic              hv,
  input  logic              isa_new,
  input  logic              bh_disable,
  input  logic              frz,
  input  logic              frz_qual,
  input  logic [2:0]        cnt_ctl,
  input  logic [SUM_W-1:0]  summary,
  output logic [FLAG_W-1:0] pm_word
);
  logic newer_block;
  logic frozen;
  logic bh_en;

  always_comb begin
    newer_block = isa_new & (bh_disable | ~pr);
    if (frz_qual) begin
      frozen = frz ? (hv & pr) : (~hv & pr);
    end else begin
      frozen = frz & pr;
    end
    bh_en = ~newer_block & ~frozen;

    pm_word          = '0;
    pm_word[FL_CC0]  = cnt_ctl[0];
    pm_word[FL_CC1]  = cnt_ctl[1];
    pm_word[FL_CJ]   = cnt_ctl[2];
    pm_word[FL_BHR]  = bh_en;
    pm_word[FL_ICNT] = |summary;
    pm_word[FL_POTH] = |summary[SUM_W-1:1];
  end
endmodule

// File: rtl/ctx_base_flags.sv
module ctx_base_flags
  import ctx_flag_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input  logic              le,
  input  logic              pr,
  input  logic              dr,
  input  logic              fp,
  input  logic              hv,
  input  logic              de,
  input  logic              st_se,
  input  logic              st_be,
  input  logic              has_hv,
  input  logic              dbg_event,
  input  logic              has_step,
  input  logic              has_btrace,
  input  logic              step_cmp,
  input  logic              branch_cmp,
  output logic [FLAG_W-1:0] base_word
);
  always_comb begin
    base_word        = '0;
    base_word[ST_LE] = le;
    base_word[ST_PR] = pr;
    base_word[ST_DR] = dr;
    base_word[ST_FP] = fp;
    base_word[FL_HV] = ~has_hv | hv;
    if (dbg_event) begin
      base_word[FL_SE] = step_cmp & de;
      base_word[FL_BE] = branch_cmp & de;
    end else begin
      base_word[FL_SE] = st_se & has_step;
      base_word[FL_BE] = st_be & has_btrace;
    end
  end
endmodule

// File: rtl/ctx_flag_encoder.sv
module ctx_flag_encoder
  import ctx_flag_pkg::*;
#(
  parameter int ST_W     = 64,
  parameter int FLAG_W   = 32,
  parameter int SUM_W    = 5,
  parameter bit CHECK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_upd,
  input  logic              pmu_upd,
  input  logic [ST_W-1:0]   st_word,
  input  logic              cfg_has_hv,
  input  logic              cfg_embedded_mmu,
  input  logic              cfg_dbg_event,
  input  logic              cfg_has_step,
  input  logic              cfg_has_btrace,
  input  logic              cfg_isa_new,
  input  logic              dbg_step_cmp,
  input  logic              dbg_branch_cmp,
  input  logic [2:0]        pm_cnt_ctl,
  input  logic              pm_frz,
  input  logic              pm_frz_qual,
  input  logic              pm_bh_disable,
  input  logic [SUM_W-1:0]  pm_summary,
  output logic [FLAG_W-1:0] flags_q,
  output logic [2:0]        iidx_q,
  output logic [2:0]        didx_q,
  output logic              mismatch
);
  localparam logic [FLAG_W-1:0] PM_MASK =
    FLAG_W'({PM_FIELD_W{1'b1}}) << FL_CC0;

  logic [FLAG_W-1:0] base_word;
  logic [FLAG_W-1:0] pm_word;
  logic [FLAG_W-1:0] fresh_word;
  logic [2:0]        iidx_fresh;
  logic [2:0]        didx_fresh;
  logic [FLAG_W-1:0] flags_d;
  logic [2:0]        iidx_d;
  logic [2:0]        didx_d;
  logic              reg_en;
  logic              unused_st_bits;

  assign unused_st_bits = ^st_word;

  ctx_base_flags #(.FLAG_W(FLAG_W)) u_base (
    .le        (st_word[ST_LE]),
    .pr        (st_word[ST_PR]),
    .dr        (st_word[ST_DR]),
    .fp        (st_word[ST_FP]),
    .hv        (st_word[ST_HV]),
    .de        (st_word[ST_DE]),
    .st_se     (st_word[ST_SE]),
    .st_be     (st_word[ST_BE]),
    .has_hv    (cfg_has_hv),
    .dbg_event (cfg_dbg_event),
    .has_step  (cfg_has_step),
    .has_btrace(cfg_has_btrace),
    .step_cmp  (dbg_step_cmp),
    .branch_cmp(dbg_branch_cmp),
    .base_word (base_word)
  );

  ctx_pmu_flags #(.FLAG_W(FLAG_W), .SUM_W(SUM_W)) u_pmu (
    .pr        (st_word[ST_PR]),
    .hv        (st_word[ST_HV]),
    .isa_new   (cfg_isa_new),
    .bh_disable(pm_bh_disable),
    .frz       (pm_frz),
    .frz_qual  (pm_frz_qual),
    .cnt_ctl   (pm_cnt_ctl),
    .summary   (pm_summary),
    .pm_word   (pm_word)
  );

  ctx_mode_index u_idx (
    .pr      (st_word[ST_PR]),
    .hv      (st_word[ST_HV]),
    .gs      (st_word[ST_GS]),
    .ir      (st_word[ST_IR]),
    .dr      (st_word[ST_DR]),
    .is_sp   (st_word[ST_IS]),
    .ds_sp   (st_word[ST_DS]),
    .embedded(cfg_embedded_mmu),
    .iidx    (iidx_fresh),
    .didx    (didx_fresh)
  );

  assign fresh_word = base_word | pm_word;

  // Next-state: full recompute has priority over the monitor-only refresh
  always_comb begin
    reg_en  = full_upd | pmu_upd;
    flags_d = flags_q;
    iidx_d  = iidx_q;
    didx_d  = didx_q;
    if (full_upd) begin
      flags_d = fresh_word;
      iidx_d  = iidx_fresh;
      didx_d  = didx_fresh;
    end else if (pmu_upd) begin
      flags_d = (flags_q & ~PM_MASK) | (pm_word & PM_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      iidx_q  <= '0;
      didx_q  <= '0;
    end else if (reg_en) begin
      flags_q <= flags_d;
      iidx_q  <= iidx_d;
      didx_q  <= didx_d;
    end
  end

  generate
    if (CHECK_EN) begin : g_chk
      assign mismatch = (flags_q != fresh_word) || (iidx_q != iidx_fresh) ||
                        (didx_q != didx_fresh);
    end else begin : g_nochk
      assign mismatch = 1'b0;
    end
  endgenerate

  // R2
  le_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_upd |=> flags_q[ST_LE] == $past(st_word[ST_LE]));
  // R3
  idx_pr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_upd |=> (iidx_q[0] == !$past(st_word[ST_PR])) && (didx_q[0] == iidx_q[0]));
  // R6
  hv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_upd && !cfg_has_hv) |=> flags_q[FL_HV]);
  // R10
  pmu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pmu_upd && !full_upd) |=> ((flags_q & ~PM_MASK) == ($past(flags_q) & ~PM_MASK))
                               && $stable(iidx_q) && $stable(didx_q));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pmu_upd && !full_upd) |=> $stable(flags_q) && $stable(iidx_q) && $stable(didx_q));
endmodule

// File: tb/ctx_flag_encoder_test.sv
module ctx_flag_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        full_upd, pmu_upd;
  logic [63:0] st_word;
  logic        cfg_has_hv, cfg_embedded_mmu, cfg_dbg_event, cfg_has_step,
               cfg_has_btrace, cfg_isa_new, dbg_step_cmp, dbg_branch_cmp;
  logic [2:0]  pm_cnt_ctl;
  logic        pm_frz, pm_frz_qual, pm_bh_disable;
  logic [4:0]  pm_summary;
  logic [31:0] flags_q;
  logic [2:0]  iidx_q, didx_q;
  logic        mismatch;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_w;
  logic [2:0]  exp_i, exp_d;
  int unsigned seed_dummy;

  always #2.5 clk = ~clk;

  ctx_flag_encoder uut (
    .clk(clk), .rst_n(rst_n), .full_upd(full_upd), .pmu_upd(pmu_upd),
    .st_word(st_word), .cfg_has_hv(cfg_has_hv), .cfg_embedded_mmu(cfg_embedded_mmu),
    .cfg_dbg_event(cfg_dbg_event), .cfg_has_step(cfg_has_step),
    .cfg_has_btrace(cfg_has_btrace), .cfg_isa_new(cfg_isa_new),
    .dbg_step_cmp(dbg_step_cmp), .dbg_branch_cmp(dbg_branch_cmp),
    .pm_cnt_ctl(pm_cnt_ctl), .pm_frz(pm_frz), .pm_frz_qual(pm_frz_qual),
    .pm_bh_disable(pm_bh_disable), .pm_summary(pm_summary),
    .flags_q(flags_q), .iidx_q(iidx_q), .didx_q(didx_q), .mismatch(mismatch)
  );

  function automatic logic bh_model();
    logic pr, hv;
    pr = st_word[14];
    hv = st_word[60];
    if (cfg_isa_new && (pm_bh_disable || !pr)) return 1'b0;
    if (pm_frz_qual) begin
      if (pm_frz && hv && pr) return 1'b0;
      if (!pm_frz && !hv && pr) return 1'b0;
    end else if (pm_frz && pr) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] pm_model();
    logic [31:0] w;
    w = '0;
    w[16] = pm_cnt_ctl[0];
    w[17] = pm_cnt_ctl[1];
    w[18] = pm_cnt_ctl[2];
    w[19] = bh_model();
    w[20] = |pm_summary;
    w[21] = |pm_summary[4:1];
    return w;
  endfunction

  function automatic logic [31:0] word_model();
    logic [31:0] w;
    w = pm_model();
    w[0]  = st_word[0];
    w[4]  = st_word[4];
    w[13] = st_word[13];
    w[14] = st_word[14];
    w[1]  = !cfg_has_hv || st_word[60];
    if (cfg_dbg_event) begin
      w[10] = dbg_step_cmp & st_word[11];
      w[9]  = dbg_branch_cmp & st_word[11];
    end else begin
      w[10] = st_word[10] & cfg_has_step;
      w[9]  = st_word[9] & cfg_has_btrace;
    end
    return w;
  endfunction

  function automatic logic [2:0] idx_model(input logic data_side);
    logic [2:0] x;
    x[0] = !st_word[14];
    if (cfg_embedded_mmu) begin
      x[2] = st_word[28];
      x[1] = data_side ? st_word[7] : st_word[8];
    end else begin
      x[2] = st_word[60];
      x[1] = data_side ? !st_word[4] : !st_word[5];
    end
    return x;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic randomize_inputs();
    st_word          = {$urandom, $urandom};
    cfg_has_hv       = 1'($urandom);
    cfg_embedded_mmu = 1'($urandom);
    cfg_dbg_event    = 1'($urandom);
    cfg_has_step     = 1'($urandom);
    cfg_has_btrace   = 1'($urandom);
    cfg_isa_new      = 1'($urandom);
    dbg_step_cmp     = 1'($urandom);
    dbg_branch_cmp   = 1'($urandom);
    pm_cnt_ctl       = 3'($urandom);
    pm_frz           = 1'($urandom);
    pm_frz_qual      = 1'($urandom);
    pm_bh_disable    = 1'($urandom);
    pm_summary       = 5'($urandom);
  endtask

  // Called at a negedge with inputs set; op: 0 idle, 1 full, 2 pmu, 3 both
  task automatic step(input int op);
    string tag;
    full_upd = (op == 1) || (op == 3);
    pmu_upd  = (op == 2) || (op == 3);
    @(posedge clk);
    @(negedge clk);
    if (full_upd) begin
      exp_w = word_model();
      exp_i = idx_model(1'b0);
      exp_d = idx_model(1'b1);
    end else if (pmu_upd) begin
      exp_w = (exp_w & ~32'h003F_0000) | pm_model();
    end
    case (op)
      1: tag = "R2 R6 R7 R8 R9 word";
      2: tag = "R10 partial word";
      3: tag = "R12 both strobes word";
      default: tag = "R11 hold word";
    endcase
    check(tag, flags_q, exp_w);
    if (op == 1 || op == 3)
      check(cfg_embedded_mmu ? "R5 R3 indices" : "R4 R3 indices",
            {26'd0, iidx_q, didx_q}, {26'd0, exp_i, exp_d});
    else
      check(op == 2 ? "R10 indices hold" : "R11 indices hold",
            {26'd0, iidx_q, didx_q}, {26'd0, exp_i, exp_d});
    check("R13 mismatch", {31'd0, mismatch},
          {31'd0, (exp_w != word_model()) || (exp_i != idx_model(1'b0)) ||
                  (exp_d != idx_model(1'b1))});
    full_upd = 1'b0;
    pmu_upd  = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0;
    full_upd = 1'b0;
    pmu_upd = 1'b0;
    randomize_inputs();
    exp_w = '0; exp_i = '0; exp_d = '0;
    repeat (3) @(negedge clk);
    check("R1 reset word", flags_q, 32'd0);
    check("R1 reset indices", {26'd0, iidx_q, didx_q}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", flags_q, 32'd0);

    // Directed: server mode, supervisor, relocation off
    randomize_inputs();
    st_word = '0; st_word[60] = 1'b1; st_word[0] = 1'b1; st_word[13] = 1'b1;
    cfg_embedded_mmu = 1'b0; cfg_has_hv = 1'b1;
    step(1);
    check("R4 server idx", {26'd0, iidx_q, didx_q}, {26'd0, 3'b111, 3'b111});
    check("R2 pass-through", flags_q & 32'h6011, 32'h2001);
    check("R6 hv set", {31'd0, flags_q[1]}, 32'd1);

    // Directed: embedded mode, problem state, spaces
    st_word = '0; st_word[14] = 1'b1; st_word[28] = 1'b1; st_word[8] = 1'b1;
    cfg_embedded_mmu = 1'b1;
    step(1);
    check("R5 embedded idx", {26'd0, iidx_q, didx_q}, {26'd0, 3'b110, 3'b100});
    check("R3 problem state bit0", {31'd0, iidx_q[0]}, 32'd0);

    // R6: no hypervisor mode, hv bit clear
    cfg_has_hv = 1'b0; st_word[60] = 1'b0;
    step(1);
    check("R6 no hv mode", {31'd0, flags_q[1]}, 32'd1);

    // R7: debug-event style gated by debug enable
    cfg_dbg_event = 1'b1; dbg_step_cmp = 1'b1; dbg_branch_cmp = 1'b0; st_word[11] = 1'b1;
    step(1);
    check("R7 debug event", {30'd0, flags_q[10], flags_q[9]}, 32'd2);
    st_word[11] = 1'b0;
    step(1);
    check("R7 debug disabled", {30'd0, flags_q[10], flags_q[9]}, 32'd0);

    // R8: summary mask
    pm_summary = 5'b00001;
    step(1);
    check("R8 count only bit0", {30'd0, flags_q[21], flags_q[20]}, 32'd1);
    pm_summary = 5'b10000;
    step(1);
    check("R8 other counter", {30'd0, flags_q[21], flags_q[20]}, 32'd3);

    // R9: freeze rule corners, exhaustive over the qualifying inputs
    for (int k = 0; k < 64; k++) begin
      cfg_isa_new = k[0]; pm_bh_disable = k[1]; st_word[14] = k[2];
      st_word[60] = k[3]; pm_frz_qual = k[4]; pm_frz = k[5];
      step(1);
      check("R9 branch history enable", {31'd0, flags_q[19]}, {31'd0, bh_model()});
    end

    // R10 / R12 directed: change state then partial, then both
    randomize_inputs();
    step(1);
    randomize_inputs();
    step(2);
    randomize_inputs();
    step(3);
    check("R12 consistent after both", {31'd0, mismatch}, 32'd0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      randomize_inputs();
      step(int'($urandom_range(0, 3)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule